// File: doc/BRIEF.md
# Carry-Select Adder/Counter Slice

A slice of identical bit cells that works either as a registered adder/subtractor or as an up/down counter. Each cell evaluates two outcomes side by side: the sum and carry-out it would produce if the incoming carry were 0, and the same pair if it were 1. Two carry chains therefore run the full width at once. The first assumes a carry of 0 into bit 0 and the second assumes a carry of 1. Within each chain, a cell's carry-out is chosen by the carry that chain brings into the cell. The effective carry into the slice picks one chain for the whole slice. At every bit, the carry on that chain selects which of the two precomputed sums is driven.

In arithmetic mode the operands come from the data inputs, and a slice-wide control chooses between addition and subtraction. In counter mode the slice adds plus or minus one to its own register. The result is always available combinationally. A register captures it under a clock enable, with a synchronous clear and a synchronous load that act on every bit.

Top module: `csel_arith_slice`

## Requirements
- R1: With count_mode_i=0 and sub_i=0, {carry_o, sum_o} equals op_a_i + op_b_i + carry_in_i as a WIDTH+1 bit unsigned sum, in the same cycle.
- R2: With count_mode_i=0 and sub_i=1, sum_o equals op_a_i - op_b_i modulo 2^WIDTH and carry_o is 1 exactly when op_a_i >= op_b_i unsigned; carry_in_i has no effect.
- R3: With clk_en_i=1, clear_i=0, load_i=0 and count_mode_i=0, acc_o after a rising edge equals the sum_o present before that edge.
- R4: With count_mode_i=1 and up_i=1, sum_o is acc_o+1 modulo 2^WIDTH and carry_o is 1 only when acc_o is all ones; op_a_i, op_b_i, sub_i and carry_in_i have no effect. With clk_en_i=1 and step_en_i=1 (no clear or load), acc_o takes that value at the edge.
- R5: With count_mode_i=1 and up_i=0, sum_o is acc_o-1 modulo 2^WIDTH and carry_o is 1 unless acc_o is zero; the register steps down under the same conditions as R4.
- R6: In counter mode with step_en_i=0 and no clear or load, acc_o keeps its value across an enabled edge.
- R7: clear_i=1 with clk_en_i=1 sets acc_o to zero at the edge, whatever load_i and the other inputs are.
- R8: load_i=1 with clear_i=0 and clk_en_i=1 sets acc_o to load_val_i at the edge, in either mode and whatever step_en_i is.
- R9: With clk_en_i=0, acc_o keeps its value across the edge even when clear_i or load_i is high.
- R10: rst_n=0 forces acc_o to zero without waiting for a clock edge; after rst_n rises the register takes no update for two rising edges.

Parameters: WIDTH (default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a_i | input | WIDTH | First operand in arithmetic mode |
| op_b_i | input | WIDTH | Second operand in arithmetic mode |
| carry_in_i | input | 1 | Carry into the slice when adding |
| sub_i | input | 1 | 1 selects subtraction in arithmetic mode |
| count_mode_i | input | 1 | 1 selects counter mode, 0 arithmetic mode |
| clk_en_i | input | 1 | Register update enable |
| step_en_i | input | 1 | Counter step enable |
| up_i | input | 1 | Count direction, 1 is up |
| clear_i | input | 1 | Synchronous clear of the register |
| load_i | input | 1 | Synchronous load of the register |
| load_val_i | input | WIDTH | Value taken on load |
| sum_o | output | WIDTH | Combinational result |
| acc_o | output | WIDTH | Registered result |
| carry_o | output | 1 | Carry out of the most significant bit on the selected chain |

## Verification
A broken link in either carry chain shows at sum_o and carry_o in the same cycle. It appears only for operand pairs whose carry runs through that bit, and only while the broken chain is the one selected. This is why both adding with each carry_in_i value and subtracting are mixed with operands that carry across the full width. A wrong register state appears on acc_o one edge later. In counter mode it then stays visible, because every later count builds on it.

// File: rtl/csel_pkg.sv
package csel_pkg;
  // Register update source, resolved by priority each enabled edge.
  typedef enum logic [1:0] {
    UPD_HOLD   = 2'd0,
    UPD_CLEAR  = 2'd1,
    UPD_LOAD   = 2'd2,
    UPD_RESULT = 2'd3
  } upd_e;
endpackage

// File: rtl/csel_bit_cell.sv
module csel_bit_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic c0_i,
  input  logic c1_i,
  input  logic use_c1_i,
  output logic c0_o,
  output logic c1_o,
  output logic sum_o
);
  logic sum_if0, sum_if1, gen_if0, gen_if1, sel_c;

  // Four 2-input functions: two sum candidates, two carry candidates.
  always_comb begin
    sum_if0 = x_i ^ y_i;
    sum_if1 = ~(x_i ^ y_i);
    gen_if0 = x_i & y_i;
    gen_if1 = x_i | y_i;
  end

  // Each chain's incoming carry picks that chain's outgoing carry.
  always_comb begin
    c0_o  = c0_i ? gen_if1 : gen_if0;
    c1_o  = c1_i ? gen_if1 : gen_if0;
    sel_c = use_c1_i ? c1_i : c0_i;
    sum_o = sel_c ? sum_if1 : sum_if0;
  end
endmodule

// File: rtl/csel_chain.sv
module csel_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] chain0;
  logic [WIDTH:0] chain1;

  assign chain0[0] = 1'b0;
  assign chain1[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    csel_bit_cell u_cell (
      .x_i      (x_i[i]),
      .y_i      (y_i[i]),
      .c0_i     (chain0[i]),
      .c1_i     (chain1[i]),
      .use_c1_i (cin_i),
      .c0_o     (chain0[i+1]),
      .c1_o     (chain1[i+1]),
      .sum_o    (sum_o[i])
    );
  end

  assign cout_o = cin_i ? chain1[WIDTH] : chain0[WIDTH];
endmodule

// File: rtl/csel_operand_mux.sv
module csel_operand_mux #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic             carry_in_i,
  input  logic             sub_i,
  input  logic             count_mode_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] x_o,
  output logic [WIDTH-1:0] y_o,
  output logic             cin_o
);
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);
  localparam logic [WIDTH-1:0] ALL_ONE = '1;

  always_comb begin
    if (count_mode_i) begin
      x_o   = acc_i;
      y_o   = up_i ? ONE : ALL_ONE;
      cin_o = 1'b0;
    end else if (sub_i) begin
      x_o   = op_a_i;
      y_o   = ~op_b_i;
      cin_o = 1'b1;
    end else begin
      x_o   = op_a_i;
      y_o   = op_b_i;
      cin_o = carry_in_i;
    end
  end
endmodule

// File: rtl/csel_state_reg.sv
module csel_state_reg
  import csel_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_i,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic             take_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic [WIDTH-1:0] result_i,
  output logic [WIDTH-1:0] acc_o
);
  upd_e             upd;
  logic [WIDTH-1:0] acc_d;
  logic [WIDTH-1:0] acc_q;

  always_comb begin
    if (!clk_en_i)   upd = UPD_HOLD;
    else if (clear_i) upd = UPD_CLEAR;
    else if (load_i)  upd = UPD_LOAD;
    else if (take_i)  upd = UPD_RESULT;
    else              upd = UPD_HOLD;
  end

  always_comb begin
    unique case (upd)
      UPD_CLEAR:  acc_d = '0;
      UPD_LOAD:   acc_d = load_val_i;
      UPD_RESULT: acc_d = result_i;
      default:    acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 acc_q <= '0;
    else if (upd != UPD_HOLD)   acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/csel_arith_slice.sv
module csel_arith_slice #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic             carry_in_i,
  input  logic             sub_i,
  input  logic             count_mode_i,
  input  logic             clk_en_i,
  input  logic             step_en_i,
  input  logic             up_i,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] acc_o,
  output logic             carry_o
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [WIDTH-1:0] x_op, y_op;
  logic             cin_eff;
  logic             take_result;

  // Asynchronous assertion, release aligned to the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  csel_operand_mux #(.WIDTH(WIDTH)) u_opmux (
    .op_a_i       (op_a_i),
    .op_b_i       (op_b_i),
    .acc_i        (acc_o),
    .carry_in_i   (carry_in_i),
    .sub_i        (sub_i),
    .count_mode_i (count_mode_i),
    .up_i         (up_i),
    .x_o          (x_op),
    .y_o          (y_op),
    .cin_o        (cin_eff)
  );

  csel_chain #(.WIDTH(WIDTH)) u_chain (
    .x_i    (x_op),
    .y_i    (y_op),
    .cin_i  (cin_eff),
    .sum_o  (sum_o),
    .cout_o (carry_o)
  );

  assign take_result = count_mode_i ? step_en_i : 1'b1;

  csel_state_reg #(.WIDTH(WIDTH)) u_state (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clk_en_i   (clk_en_i),
    .clear_i    (clear_i),
    .load_i     (load_i),
    .take_i     (take_result),
    .load_val_i (load_val_i),
    .result_i   (sum_o),
    .acc_o      (acc_o)
  );
endmodule

// File: rtl/csel_arith_slice_chk.sv
module csel_arith_slice_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [WIDTH-1:0] op_a_i,
  input logic [WIDTH-1:0] op_b_i,
  input logic             carry_in_i,
  input logic             sub_i,
  input logic             count_mode_i,
  input logic             clk_en_i,
  input logic             step_en_i,
  input logic             clear_i,
  input logic             load_i,
  input logic [WIDTH-1:0] load_val_i,
  input logic [WIDTH-1:0] sum_o,
  input logic [WIDTH-1:0] acc_o,
  input logic             carry_o
);
  logic [WIDTH:0] add_ref;
  assign add_ref = {1'b0, op_a_i} + {1'b0, op_b_i} + {{WIDTH{1'b0}}, carry_in_i};

  // R1: adder result matches a behavioural sum
  a_r1_add_matches: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!count_mode_i && !sub_i) |-> ({carry_o, sum_o} == add_ref));

  // R2: borrow-free flag in subtraction
  a_r2_sub_carry: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!count_mode_i && sub_i) |-> (carry_o == (op_a_i >= op_b_i)));

  // R3: register captures the previous combinational result
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en_i && !clear_i && !load_i && !count_mode_i) |=> (acc_o == $past(sum_o)));

  // R6: no step when step enable is low
  a_r6_step_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en_i && !clear_i && !load_i && count_mode_i && !step_en_i) |=> $stable(acc_o));

  // R7: clear wins
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en_i && clear_i) |=> (acc_o == '0));

  // R8: load below clear
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en_i && !clear_i && load_i) |=> (acc_o == $past(load_val_i)));

  // R9: disabled edge changes nothing
  a_r9_ce_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clk_en_i |=> $stable(acc_o));
endmodule

bind csel_arith_slice csel_arith_slice_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .op_a_i       (op_a_i),
  .op_b_i       (op_b_i),
  .carry_in_i   (carry_in_i),
  .sub_i        (sub_i),
  .count_mode_i (count_mode_i),
  .clk_en_i     (clk_en_i),
  .step_en_i    (step_en_i),
  .clear_i      (clear_i),
  .load_i       (load_i),
  .load_val_i   (load_val_i),
  .sum_o        (sum_o),
  .acc_o        (acc_o),
  .carry_o      (carry_o)
);

// File: tb/csel_arith_slice_bench.sv
module csel_arith_slice_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] op_a, op_b, load_val;
  logic         cin, sub, cmode, ce, sten, up, clr, ld;
  logic [W-1:0] sum, acc;
  logic         cout;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  logic [W-1:0] acc_exp;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  csel_arith_slice #(.WIDTH(W)) u_csel_arith_slice (
    .clk(clk), .rst_n(rst_n), .op_a_i(op_a), .op_b_i(op_b), .carry_in_i(cin),
    .sub_i(sub), .count_mode_i(cmode), .clk_en_i(ce), .step_en_i(sten),
    .up_i(up), .clear_i(clr), .load_i(ld), .load_val_i(load_val),
    .sum_o(sum), .acc_o(acc), .carry_o(cout)
  );

  function automatic logic [W:0] exp_comb(input logic [W-1:0] q);
    logic [W:0] a, b, c;
    if (cmode) begin
      a = {1'b0, q};
      b = up ? (W+1)'(1) : {1'b0, {W{1'b1}}};
      c = '0;
    end else begin
      a = {1'b0, op_a};
      b = {1'b0, sub ? ~op_b : op_b};
      c = (W+1)'(sub ? 1'b1 : cin);
    end
    return a + b + c;
  endfunction

  function automatic logic [W-1:0] exp_next(input logic [W-1:0] q);
    logic [W:0] r;
    r = exp_comb(q);
    if (!ce) return q;
    if (clr) return '0;
    if (ld) return load_val;
    if (cmode && !sten) return q;
    return r[W-1:0];
  endfunction

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, expv);
    end
  endtask

  function automatic string req_of();
    if (!cmode) return sub ? "R2" : "R1";
    return up ? "R4" : "R5";
  endfunction

  function automatic string reg_req();
    if (!ce) return "R9";
    if (clr) return "R7";
    if (ld) return "R8";
    if (!cmode) return "R3";
    if (!sten) return "R6";
    return up ? "R4" : "R5";
  endfunction

  task automatic idle();
    op_a = '0; op_b = '0; load_val = '0; cin = 0; sub = 0; cmode = 0;
    ce = 0; sten = 0; up = 0; clr = 0; ld = 0;
  endtask

  // One vector: drive at negedge, check comb, then check register next negedge.
  task automatic apply();
    string rq;
    #1;
    check(req_of(), {cout, sum}, exp_comb(acc_exp));
    rq = reg_req();
    acc_exp = exp_next(acc_exp);
    @(negedge clk);
    check(rq, {1'b0, acc}, {1'b0, acc_exp});
  endtask

  task automatic rand_vec();
    op_a = W'($urandom); op_b = W'($urandom); load_val = W'($urandom);
    cin = 1'($urandom); sub = 1'($urandom); cmode = 1'($urandom);
    ce = ($urandom % 8) != 0; sten = ($urandom % 4) != 0; up = 1'($urandom);
    clr = ($urandom % 16) == 0; ld = ($urandom % 8) == 0;
  endtask

  initial begin
    void'($urandom(32'h1d5e_07a3));
    idle();
    rst_n = 0;
    acc_exp = '0;
    repeat (3) @(negedge clk);
    check("R10", {1'b0, acc}, '0);
    rst_n = 1;
    // R10: during the two-edge release window a load must not land
    ce = 1; ld = 1; load_val = 8'h5a;
    @(negedge clk);
    check("R10", {1'b0, acc}, '0);
    idle();
    repeat (2) @(negedge clk);

    // Directed: R1 full-width carry with carry_in 1
    op_a = 8'hff; op_b = 8'h00; cin = 1; ce = 1; apply();
    op_a = 8'h80; op_b = 8'h80; cin = 0; apply();
    // R2: zero minus one, equal operands, carry_in ignored
    sub = 1; op_a = 8'h00; op_b = 8'h01; cin = 0; apply();
    op_a = 8'h3c; op_b = 8'h3c; cin = 1; apply();
    // R8 load all ones, R4 wrap upward
    sub = 0; ld = 1; load_val = 8'hff; apply();
    ld = 0; cmode = 1; sten = 1; up = 1; op_a = 8'h12; sub = 1; apply();
    // R5 wrap downward from zero
    up = 0; apply();
    // R6 hold
    sten = 0; apply();
    // R7 clear beats load
    clr = 1; ld = 1; load_val = 8'h77; apply();
    // R9 disabled edge with clear and load high
    clr = 0; ld = 1; load_val = 8'h33; apply();
    ld = 0; ce = 0; clr = 1; apply();
    ld = 1; clr = 0; apply();

    for (int i = 0; i < 3000; i++) begin
      rand_vec();
      apply();
    end

    // R10: asynchronous reset without a clock edge
    idle();
    #2 rst_n = 0;
    #1 check("R10", {1'b0, acc}, '0);
    acc_exp = '0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule